// File: doc/BRIEF.md
# Sixteen-bit Dual-Compare Waveform Timer

This block is a 16-bit counter that advances on a selectable tick and drives two waveform pins from two compare channels. The tick comes from a prescaler pulse, from a rising or falling edge on an external pin, or from nowhere, in which case the count stays where it is. Each channel has a write-side buffer and an active compare value. The active value is matched against the count, and the result steers a toggle output or a pulse-width output.

Four waveform modes set the counting range and where the count turns around. In plain counting the count runs over the full range. In clear-on-match the count restarts after reaching channel A's active value. Single-slope PWM climbs to a programmable limit and restarts. Dual-slope PWM climbs to that limit and then falls back to zero. An overflow flag and one match flag per channel are collected in a flag register. A mask register selects which flags drive the single interrupt line.

The count direction is held in a two-state machine: `ST_COUNT_UP` and `ST_COUNT_DOWN`. Its transitions are:
- *turn-down*: in dual-slope mode, moving from `ST_COUNT_UP` to `ST_COUNT_DOWN` on a tick that finds the count at or above the limit.
- *turn-up*: moving from `ST_COUNT_DOWN` to `ST_COUNT_UP` on a tick that finds the count at zero.
- *force-up*: any mode other than dual-slope returns the machine to `ST_COUNT_UP`.

Top module: `pwm_timer16`

## Requirements
- R1: After reset the count is zero, the machine is in `ST_COUNT_UP`, and every flag, mask bit, waveform pin and the interrupt line are 0.
- R2: Control bits [1:0] select the tick source:
  - 0: no tick, and the count holds.
  - 1: `presc_tick`.
  - 2: a rising edge of `ext_pin`.
  - 3: a falling edge of `ext_pin`.
  The pin passes through two synchronising flops before edge detection, and each edge yields exactly one tick.
- R3: In plain counting (control bits [3:2] = 0), each tick adds one to the count.
  - A tick at 0xFFFF wraps the count to 0 and sets the overflow flag.
  - Active compare values follow their buffers one cycle after a write.
  - A compare match toggles the channel's pin.
- R4: In clear-on-match (mode 1), a tick at a count equal to channel A's active value reloads the count to 0 and sets the overflow flag. Pins toggle on match.
- R5: In single-slope PWM (mode 2), a tick at a count at or above the limit register reloads the count to 0, sets the overflow flag and drives every pin to 1. Otherwise a match drives the pin to 0. On the same tick, the reload takes priority over a match.
- R6: In dual-slope PWM (mode 3), the count rises to the limit and then falls to 0, following turn-down and turn-up.
  - The overflow flag is set at turn-up.
  - A match drives the pin to 0 while counting up and to 1 while counting down.
- R7: In both PWM modes a channel's active value is loaded from its buffer only on the tick that reaches the limit (turn-down in dual-slope mode). In modes 0 and 1 the load happens every cycle.
- R8: A match flag is set on a tick at which the count equals that channel's active value.
- R9: Flag register layout:
  - bit 0: channel A match.
  - bit 1: channel B match.
  - bit 2: overflow.
  Writing 1 to a bit at address 5 clears that bit. A hardware set in the same cycle wins over the clear.
- R10: `irq` is high exactly when some flag is set together with its mask bit. The mask is written at address 6 and has the same bit layout as the flags.
- R11: Writing the count (address 0) replaces it on the next edge, overriding any tick in that cycle. The direction is left unchanged.
- R12: Write addresses:

  | Address | Register |
  |---|---|
  | 0 | count |
  | 1 | compare buffer A |
  | 2 | compare buffer B |
  | 3 | limit |
  | 4 | control (tick source in bits [1:0], mode in bits [3:2]) |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_tick | input | 1 | One-cycle pulse from the prescaler |
| ext_pin | input | 1 | Asynchronous external count pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| wave_out | output | 2 | Waveform pins, bit 0 channel A, bit 1 channel B |
| flags | output | 3 | Flag register |
| irq_mask | output | 3 | Mask register |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `ext_pin` holds each level for several clocks, so that no two edges fall within the synchroniser window. They also assume that the tick source is not changed in the cycle after an external tick. The dual-slope checks assume a limit of at least 1. The stimulus respects all of these:
- it holds the external pin for three clocks per level;
- it changes the tick source only while the pin is idle;
- it programs limits of 6 and 9.

The bench model computes pins and flags from the written registers alone, and that result is compared on every falling edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NUM_CH = 2;
    localparam int FLAG_W = NUM_CH + 1;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {CS_NONE, CS_PRESC, CS_EXT_RISE, CS_EXT_FALL} clk_sel_e;
    typedef enum logic [1:0] {WM_NORMAL, WM_CTC, WM_FAST_PWM, WM_PHASE_PWM} wave_mode_e;
    typedef enum logic {ST_COUNT_UP, ST_COUNT_DOWN} dir_state_e;

    localparam logic [ADDR_W-1:0] A_COUNT   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMPA    = 3'd1;
    localparam logic [ADDR_W-1:0] A_TOP     = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAGCLR = 3'd5;
    localparam logic [ADDR_W-1:0] A_MASK    = 3'd6;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  clk_sel_e sel,
    input  logic     presc_tick,
    input  logic     ext_pin,
    output logic     tick
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh;
    logic            rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SH_W-2:0], ext_pin};
    end

    assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
    assign fall = ~sh[SYNC_STAGES-1] & sh[SYNC_STAGES];

    always_comb begin
        unique case (sel)
            CS_NONE:     tick = 1'b0;
            CS_PRESC:    tick = presc_tick;
            CS_EXT_RISE: tick = rise;
            CS_EXT_FALL: tick = fall;
            default:     tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  wave_mode_e   mode,
    input  logic [W-1:0] top_val,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output dir_state_e   dir,
    output logic         top_evt,
    output logic         ovf_evt
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    dir_state_e   state, nxt_state;
    logic [W-1:0] nxt_cnt;
    logic         at_top;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_COUNT_UP;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    assign dir    = state;
    assign at_top = (mode == WM_CTC) ? (cnt == top_val) : (cnt >= top_val);

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        top_evt   = 1'b0;
        ovf_evt   = 1'b0;
        unique case (mode)
            WM_NORMAL: begin
                nxt_state = ST_COUNT_UP;
                if (tick) begin
                    nxt_cnt = cnt + ONE;
                    top_evt = (cnt == MAXV);
                    ovf_evt = (cnt == MAXV);
                end
            end
            WM_CTC, WM_FAST_PWM: begin
                nxt_state = ST_COUNT_UP;
                if (tick) begin
                    if (at_top) begin
                        nxt_cnt = '0;
                        top_evt = 1'b1;
                        ovf_evt = 1'b1;
                    end else begin
                        nxt_cnt = cnt + ONE;
                    end
                end
            end
            WM_PHASE_PWM: begin
                unique case (state)
                    ST_COUNT_UP: if (tick) begin
                        if (at_top) begin
                            nxt_state = ST_COUNT_DOWN;
                            nxt_cnt   = (cnt == '0) ? '0 : cnt - ONE;
                            top_evt   = 1'b1;
                        end else begin
                            nxt_cnt = cnt + ONE;
                        end
                    end
                    ST_COUNT_DOWN: if (tick) begin
                        if (cnt == '0) begin
                            nxt_state = ST_COUNT_UP;
                            nxt_cnt   = (top_val == '0) ? '0 : ONE;
                            ovf_evt   = 1'b1;
                        end else begin
                            nxt_cnt = cnt - ONE;
                        end
                    end
                    default: nxt_state = ST_COUNT_UP;
                endcase
            end
            default: nxt_state = ST_COUNT_UP;
        endcase
        if (ld_en) nxt_cnt = ld_val;
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  wave_mode_e   mode,
    input  dir_state_e   dir,
    input  logic [W-1:0] cnt,
    input  logic         top_evt,
    input  logic         wr_buf,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] act,
    output logic         match,
    output logic         wave
);
    logic [W-1:0] buf_val;
    logic         pwm_mode;

    assign pwm_mode = (mode == WM_FAST_PWM) || (mode == WM_PHASE_PWM);
    assign match    = tick && (cnt == act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_val <= '0;
            act     <= '0;
        end else begin
            if (wr_buf) buf_val <= wr_val;
            if (!pwm_mode || top_evt) act <= buf_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wave <= 1'b0;
        end else begin
            unique case (mode)
                WM_NORMAL, WM_CTC: if (match) wave <= ~wave;
                WM_FAST_PWM: begin
                    if (top_evt)    wave <= 1'b1;
                    else if (match) wave <= 1'b0;
                end
                WM_PHASE_PWM: if (match) wave <= (dir == ST_COUNT_DOWN);
                default: wave <= wave;
            endcase
        end
    end
endmodule

// File: rtl/pwm_timer16.sv
module pwm_timer16
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              presc_tick,
    input  logic              ext_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [NUM_CH-1:0] wave_out,
    output logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] irq_mask,
    output logic              irq
);
    clk_sel_e          clk_sel;
    wave_mode_e        mode;
    dir_state_e        dir;
    logic [W-1:0]      top_reg, top_val, cnt;
    logic              tick, top_evt, ovf_evt;
    logic [W-1:0]      cmp_act [NUM_CH];
    logic [NUM_CH-1:0] match;
    logic [FLAG_W-1:0] flag_clr;
    logic              unused_bits;

    assign unused_bits = ^wr_data[W-1:4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sel  <= CS_NONE;
            mode     <= WM_NORMAL;
            top_reg  <= '0;
            irq_mask <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                clk_sel <= clk_sel_e'(wr_data[1:0]);
                mode    <= wave_mode_e'(wr_data[3:2]);
            end
            if (wr_addr == A_TOP)  top_reg  <= wr_data;
            if (wr_addr == A_MASK) irq_mask <= wr_data[FLAG_W-1:0];
        end
    end

    tmr_tick_sel #(.SYNC_STAGES(2)) u_tick (
        .clk(clk), .rst_n(rst_n), .sel(clk_sel), .presc_tick(presc_tick),
        .ext_pin(ext_pin), .tick(tick)
    );

    always_comb begin
        unique case (mode)
            WM_NORMAL: top_val = '1;
            WM_CTC:    top_val = cmp_act[0];
            default:   top_val = top_reg;
        endcase
    end

    tmr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .top_val(top_val),
        .ld_en(wr_en && wr_addr == A_COUNT), .ld_val(wr_data),
        .cnt(cnt), .dir(dir), .top_evt(top_evt), .ovf_evt(ovf_evt)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tmr_channel #(.W(W)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .dir(dir),
            .cnt(cnt), .top_evt(top_evt),
            .wr_buf(wr_en && wr_addr == (A_CMPA + ADDR_W'(i))), .wr_val(wr_data),
            .act(cmp_act[i]), .match(match[i]), .wave(wave_out[i])
        );
    end

    assign flag_clr = (wr_en && wr_addr == A_FLAGCLR) ? wr_data[FLAG_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flag_clr) | {ovf_evt, match};
    end

    assign irq = |(flags & irq_mask);
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [W-1:0]      wr_data,
    input logic [FLAG_W-1:0] flags,
    input logic [FLAG_W-1:0] irq_mask,
    input logic              irq,
    input logic              tick,
    input clk_sel_e          clk_sel,
    input wave_mode_e        mode,
    input dir_state_e        dir,
    input logic [W-1:0]      cnt,
    input logic              top_evt,
    input logic [W-1:0]      act_a
);
    logic [FLAG_W-1:0] keep_vec;
    logic              ext_tick;

    assign keep_vec = flags & ~((wr_en && wr_addr == A_FLAGCLR) ? wr_data[FLAG_W-1:0] : '0);
    assign ext_tick = tick && (clk_sel == CS_EXT_RISE || clk_sel == CS_EXT_FALL);

    // R9
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(keep_vec)) == $past(keep_vec)));

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == '0) |-> !irq);

    // R2
    frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == CS_NONE && !(wr_en && wr_addr == A_COUNT)) |=> $stable(cnt));

    // R2
    one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_tick |=> !ext_tick);

    // R3
    ovf_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLAG_W-1]) |-> $past(tick));

    // R7
    pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == WM_FAST_PWM || mode == WM_PHASE_PWM) && !top_evt) |=> $stable(act_a));

    // R6
    dir_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != WM_PHASE_PWM) |=> (dir == ST_COUNT_UP));
endmodule

bind pwm_timer16 tmr_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flags(flags), .irq_mask(irq_mask), .irq(irq), .tick(tick), .clk_sel(clk_sel),
    .mode(mode), .dir(dir), .cnt(cnt), .top_evt(top_evt), .act_a(cmp_act[0])
);

// File: tb/test_pwm_timer16.sv
module test_pwm_timer16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        presc_tick = 1'b0;
    logic        ext_pin = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  wave_out;
    logic [2:0]  flags, irq_mask;
    logic        irq;

    int    n_chk = 0, n_fail = 0, cyc = 0, div = 1;
    string cur_req = "R1";
    bit    done = 1'b0;

    pwm_timer16 i_pwm_timer16 (
        .clk(clk), .rst_n(rst_n), .presc_tick(presc_tick), .ext_pin(ext_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wave_out(wave_out), .flags(flags), .irq_mask(irq_mask), .irq(irq)
    );

    always #2 clk = ~clk;

    // behavioural reference model
    logic [15:0] m_cnt, m_top, m_buf [2], m_act [2];
    logic [1:0]  m_sel, m_mode, m_wave;
    logic [2:0]  m_flags, m_mask;
    logic        m_down, p1, p2, p3;

    always @(posedge clk) begin : model
        logic t, ovf, upd;
        logic [1:0] mt;
        logic [15:0] lim;
        if (!rst_n) begin
            m_cnt = 0; m_top = 0; m_sel = 0; m_mode = 0; m_wave = 0;
            m_flags = 0; m_mask = 0; m_down = 0; p1 = 0; p2 = 0; p3 = 0;
            for (int i = 0; i < 2; i++) begin m_buf[i] = 0; m_act[i] = 0; end
        end else begin
            case (m_sel)
                2'd1: t = presc_tick;
                2'd2: t = p2 & ~p3;
                2'd3: t = ~p2 & p3;
                default: t = 1'b0;
            endcase
            p3 = p2; p2 = p1; p1 = ext_pin;
            lim = (m_mode == 0) ? 16'hFFFF : (m_mode == 1) ? m_act[0] : m_top;
            for (int i = 0; i < 2; i++) mt[i] = t && (m_cnt == m_act[i]);
            ovf = 0; upd = 0;
            if (t) begin
                if (m_mode == 0) begin
                    ovf = (m_cnt == 16'hFFFF); m_cnt = m_cnt + 1;
                end else if (m_mode == 1) begin
                    if (m_cnt == lim) begin m_cnt = 0; ovf = 1; end else m_cnt = m_cnt + 1;
                end else if (m_mode == 2) begin
                    if (m_cnt >= lim) begin m_cnt = 0; ovf = 1; upd = 1; end else m_cnt = m_cnt + 1;
                end else if (!m_down) begin
                    if (m_cnt >= lim) begin upd = 1; m_down = 1; if (m_cnt != 0) m_cnt = m_cnt - 1; end
                    else m_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin ovf = 1; m_down = 0; m_cnt = (lim == 0) ? 16'd0 : 16'd1; end
                    else m_cnt = m_cnt - 1;
                end
            end
            for (int i = 0; i < 2; i++) begin
                if (m_mode < 2) begin
                    if (mt[i]) m_wave[i] = ~m_wave[i];
                end else if (m_mode == 2) begin
                    if (ovf) m_wave[i] = 1; else if (mt[i]) m_wave[i] = 0;
                end else if (mt[i]) m_wave[i] = m_down_old(upd, ovf, t);
                if (m_mode < 2 || upd) m_act[i] = m_buf[i];
            end
            m_flags = (m_flags & ~((wr_en && wr_addr == 5) ? wr_data[2:0] : 3'b0)) | {ovf, mt};
            if (m_mode != 3) m_down = 0;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_cnt = wr_data;
                    3'd1: m_buf[0] = wr_data;
                    3'd2: m_buf[1] = wr_data;
                    3'd3: m_top = wr_data;
                    3'd4: begin m_sel = wr_data[1:0]; m_mode = wr_data[3:2]; end
                    3'd6: m_mask = wr_data[2:0];
                    default: ;
                endcase
            end
        end
    end

    // direction before this tick's turn (R6): undo the turn just applied to m_down
    function automatic logic m_down_old(logic upd_i, logic ovf_i, logic t_i);
        if (t_i && upd_i) return 1'b0;
        if (t_i && ovf_i) return 1'b1;
        return m_down;
    endfunction

    task automatic chk(input bit ok, input string req, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done)
            chk({wave_out, flags, irq_mask, irq} ==
                {m_wave, m_flags, m_mask, |(m_flags & m_mask)}, cur_req,
                $sformatf("w=%b f=%b m=%b i=%b", wave_out, flags, irq_mask, irq),
                $sformatf("w=%b f=%b m=%b i=%b", m_wave, m_flags, m_mask, |(m_flags & m_mask)));
        presc_tick <= (div != 0) && (cyc % div == 0);
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected<20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); wr_en <= 1'b1; wr_addr <= a; wr_data <= d;
        @(negedge clk); wr_en <= 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < 2 * n; i++) begin
            @(negedge clk); ext_pin <= ~ext_pin;
            idle(2);
        end
    endtask

    initial begin
        idle(3);
        // R1: reset state at the ports
        chk({wave_out, flags, irq_mask, irq} == '0, "R1",
            $sformatf("%b", {wave_out, flags, irq_mask, irq}), "0");
        rst_n = 1'b1;
        idle(2);
        chk({wave_out, flags, irq} == '0, "R1", $sformatf("%b", {wave_out, flags, irq}), "0");

        // R12, R3, R8: plain counting over the wrap, address map
        cur_req = "R3";
        wr(3'd6, 16'h0007);
        wr(3'd1, 16'd5); wr(3'd2, 16'hFFF8);
        wr(3'd0, 16'hFFF0);
        wr(3'd4, 16'h0001);
        idle(40);
        cur_req = "R8"; div = 3; idle(30);

        // R9: clears, including ones that collide with hardware sets
        cur_req = "R9"; div = 1;
        for (int i = 0; i < 12; i++) wr(3'd5, 16'h0007);
        // R10: mask changes
        cur_req = "R10";
        wr(3'd6, 16'h0000); idle(20);
        wr(3'd6, 16'h0004); idle(20);

        // R2: frozen, then external rising and falling edges
        cur_req = "R2";
        wr(3'd4, 16'h0000); idle(20);
        wr(3'd0, 16'd0);
        wr(3'd4, 16'h0002); pulses(8);
        wr(3'd4, 16'h0003); pulses(8);

        // R4: clear on match with channel A as the limit
        cur_req = "R4";
        wr(3'd1, 16'd7); wr(3'd2, 16'd3); wr(3'd0, 16'd0);
        div = 2; wr(3'd4, 16'h0005); idle(60);

        // R5: single slope, channel B at the limit stays high
        cur_req = "R5";
        wr(3'd3, 16'd9); wr(3'd1, 16'd4); wr(3'd2, 16'd9);
        div = 1; wr(3'd4, 16'h0009); idle(40);
        // R7: buffer change mid period lands at the limit
        cur_req = "R7";
        wr(3'd1, 16'd2); idle(30);
        // R11: count write beyond the limit
        cur_req = "R11";
        wr(3'd0, 16'h0020); idle(20);

        // R6: dual slope
        cur_req = "R6";
        wr(3'd3, 16'd6); wr(3'd1, 16'd3); wr(3'd2, 16'd0);
        wr(3'd4, 16'h000D); idle(60);
        cur_req = "R7"; wr(3'd1, 16'd5); idle(40);
        cur_req = "R11"; wr(3'd0, 16'd2); idle(30);
        cur_req = "R6"; wr(3'd4, 16'h0001); idle(20);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule